// File: doc/BRIEF.md
# Priority-Based Dynamic Frame Slicer

This block shortens captured Ethernet frames before they are written to host memory. Frames arrive one byte per beat on a valid/ready stream. On the final beat the classifier also supplies two header sizes, a filter-match bit vector and a 64-bit timestamp. Software programs a small table of slicing rules. Each rule names a filter bit that qualifies it, a priority, a byte offset, and a base. The base is zero, the combined layer 2 and 3 header size, or the combined layer 2, 3 and 4 header size.

Each frame is written into a local buffer. When the final byte arrives, the block picks the winning rule among those that apply and computes the cut point as base plus offset. It then emits a 16-byte capture descriptor followed by the kept bytes. The descriptor carries the kept length, the length seen on the wire and the timestamp. The next frame is not accepted until the current one has been fully emitted.

Top module: `frame_slicer`

## Requirements
- R1: After reset `in_ready` is 1, `out_valid` is 0 and every rule is disabled.
- R2: Every emitted frame begins with 16 descriptor bytes, little-endian 32-bit words. Word 0 holds the capture length in bits 15:0 and the wire length in bits 31:16. Word 1 holds timestamp bits 63:32, word 2 holds timestamp bits 31:0 and word 3 is zero. The kept frame bytes follow from output byte 16 on, in their original order.
- R3: A rule with base select 0 cuts the frame at its offset alone.
- R4: A rule with base select 1 cuts at `in_l23_len` plus its offset.
- R5: A rule with base select 2 cuts at `in_l234_len` plus its offset.
- R6: A rule applies only when it is enabled and bit `fidx` of `in_filt` is 1. A disabled rule, or one whose bit is 0, has no effect on the output.
- R7: Among the applying rules, the lowest priority value wins. On equal priority the lower table index wins.
- R8: If the cut point is at or beyond the frame end, every byte is kept and the capture length equals the wire length.
- R9: If no rule applies, the frame is not sliced.
- R10: The capture length never exceeds BUF_DEPTH, and the wire length always reports the full received length.
- R11: While the output stalls, `out_valid`, `out_data` and `out_last` hold. `in_ready` stays 0 from the accepted last input beat until the last output byte is taken.
- R12: A cut point of 0 emits the descriptor alone, with `out_last` on descriptor byte 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write one rule table entry |
| cfg_sel | input | $clog2(NUM_RULES) | Entry to write |
| cfg_en | input | 1 | Entry enable |
| cfg_prio | input | PRIO_W | Entry priority, lower wins |
| cfg_offset | input | 16 | Byte offset added to the base |
| cfg_base | input | 2 | Base select: 0 none, 1 L2+L3 size, 2 L2+L3+L4 size |
| cfg_fidx | input | $clog2(FILT_W) | Filter bit that qualifies the entry |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Final byte of the frame |
| in_l23_len | input | 16 | L2+L3 header size, sampled with the last byte |
| in_l234_len | input | 16 | L2+L3+L4 header size, sampled with the last byte |
| in_filt | input | FILT_W | Filter match bits, sampled with the last byte |
| in_ts | input | 64 | Frame timestamp, sampled with the last byte |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Output byte taken |
| out_data | output | 8 | Descriptor or frame byte |
| out_last | output | 1 | Final output byte of the frame |

## Verification
The bench builds the block with BUF_DEPTH of 64 and keeps the defaults of four rules, eight filter bits and three priority bits. The small buffer lets a 100-byte frame reach the capacity limit of R10 within a short run. The four-entry table is enough to stack a catch-all rule, an IP rule and a TCP rule, and to set up an equal-priority tie. Output readiness is switched between always ready, a pseudo-random pattern and a long stall, so the hold behaviour of R11 is exercised in the middle of frames.

// File: rtl/frame_slicer.sv
module frame_slicer #(
  parameter int BUF_DEPTH = 2048,
  parameter int NUM_RULES = 4,
  parameter int FILT_W    = 8,
  parameter int PRIO_W    = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_we,
  input  logic [$clog2(NUM_RULES)-1:0] cfg_sel,
  input  logic                         cfg_en,
  input  logic [PRIO_W-1:0]            cfg_prio,
  input  logic [15:0]                  cfg_offset,
  input  logic [1:0]                   cfg_base,
  input  logic [$clog2(FILT_W)-1:0]    cfg_fidx,
  input  logic                         in_valid,
  output logic                         in_ready,
  input  logic [7:0]                   in_data,
  input  logic                         in_last,
  input  logic [15:0]                  in_l23_len,
  input  logic [15:0]                  in_l234_len,
  input  logic [FILT_W-1:0]            in_filt,
  input  logic [63:0]                  in_ts,
  output logic                         out_valid,
  input  logic                         out_ready,
  output logic [7:0]                   out_data,
  output logic                         out_last
);
  localparam int AW  = $clog2(BUF_DEPTH);
  localparam int RIW = $clog2(NUM_RULES);
  localparam int FIW = $clog2(FILT_W);
  localparam int TW  = $clog2(BUF_DEPTH + 16);
  localparam logic [16:0] DEPTH_L = 17'(BUF_DEPTH);

  logic              r_en   [NUM_RULES];
  logic [PRIO_W-1:0] r_prio [NUM_RULES];
  logic [15:0]       r_off  [NUM_RULES];
  logic [1:0]        r_base [NUM_RULES];
  logic [FIW-1:0]    r_fidx [NUM_RULES];

  logic [7:0]  mem [BUF_DEPTH];
  logic        busy;
  logic [16:0] wcnt;
  logic [16:0] cap_q;
  logic [15:0] wire_q;
  logic [63:0] ts_q;
  logic [TW-1:0] tx_idx, last_q, rd_full;

  logic              hit;
  logic [PRIO_W-1:0] best_p;
  logic [16:0]       best_cut, cand, wire_now, lim, cap_now;
  logic [127:0]      desc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_RULES; i++) begin
        r_en[i]   <= 1'b0;
        r_prio[i] <= '0;
        r_off[i]  <= '0;
        r_base[i] <= '0;
        r_fidx[i] <= '0;
      end
    end else if (cfg_we) begin
      r_en[cfg_sel]   <= cfg_en;
      r_prio[cfg_sel] <= cfg_prio;
      r_off[cfg_sel]  <= cfg_offset;
      r_base[cfg_sel] <= cfg_base;
      r_fidx[cfg_sel] <= cfg_fidx;
    end
  end

  always_comb begin
    hit = 1'b0;
    best_p = '0;
    best_cut = '0;
    cand = '0;
    for (int i = 0; i < NUM_RULES; i++) begin
      cand = {1'b0, r_off[i]};
      if (r_base[i] == 2'd1) cand = cand + {1'b0, in_l23_len};
      else if (r_base[i] == 2'd2) cand = cand + {1'b0, in_l234_len};
      if (r_en[i] && in_filt[r_fidx[i]] && (!hit || r_prio[i] < best_p)) begin
        hit = 1'b1;
        best_p = r_prio[i];
        best_cut = cand;
      end
    end
  end

  assign wire_now = wcnt + 17'd1;
  assign lim      = (hit && best_cut < wire_now) ? best_cut : wire_now;
  assign cap_now  = (lim > DEPTH_L) ? DEPTH_L : lim;

  assign in_ready  = !busy;
  assign out_valid = busy;
  assign desc      = {32'h0, ts_q[31:0], ts_q[63:32], wire_q, cap_q[15:0]};
  assign rd_full   = tx_idx - TW'(16);
  assign out_data  = (tx_idx < TW'(16)) ? desc[{tx_idx[3:0], 3'b000} +: 8]
                                        : mem[rd_full[AW-1:0]];
  assign out_last  = busy && (tx_idx == last_q);

  always_ff @(posedge clk) begin
    if (in_valid && !busy && wcnt < DEPTH_L) mem[wcnt[AW-1:0]] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      wcnt   <= '0;
      cap_q  <= '0;
      wire_q <= '0;
      ts_q   <= '0;
      tx_idx <= '0;
      last_q <= '0;
    end else if (!busy) begin
      if (in_valid) begin
        if (in_last) begin
          busy   <= 1'b1;
          wcnt   <= '0;
          cap_q  <= cap_now;
          wire_q <= wire_now[15:0];
          ts_q   <= in_ts;
          tx_idx <= '0;
          last_q <= TW'(cap_now) + TW'(15);
        end else begin
          wcnt <= wcnt + 17'd1;
        end
      end
    end else if (out_ready) begin
      tx_idx <= tx_idx + TW'(1);
      if (out_last) busy <= 1'b0;
    end
  end

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));
  a_r11_release: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> in_ready && !out_valid);
  a_r2_start: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_last |=> out_valid && !in_ready && tx_idx == '0);
  a_r8_cap_le_wire: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> cap_q <= {1'b0, wire_q});
  a_r10_cap_depth: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> cap_q <= DEPTH_L);
  a_r12_desc_first: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> tx_idx >= TW'(15));
endmodule

// File: tb/frame_slicer_tb.sv
module frame_slicer_tb;
  localparam int DEPTH = 64;
  localparam int NR = 4;
  localparam int FW = 8;
  localparam int PW = 3;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_en = 0;
  logic [1:0] cfg_sel = 0, cfg_base = 0;
  logic [PW-1:0] cfg_prio = 0;
  logic [15:0] cfg_offset = 0;
  logic [2:0] cfg_fidx = 0;
  logic in_valid = 0, in_last = 0, in_ready;
  logic [7:0] in_data = 0;
  logic [15:0] in_l23_len = 0, in_l234_len = 0;
  logic [FW-1:0] in_filt = 0;
  logic [63:0] in_ts = 0;
  logic out_valid, out_last, out_ready = 1;
  logic [7:0] out_data;

  frame_slicer #(.BUF_DEPTH(DEPTH), .NUM_RULES(NR), .FILT_W(FW), .PRIO_W(PW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_en(cfg_en),
    .cfg_prio(cfg_prio), .cfg_offset(cfg_offset), .cfg_base(cfg_base), .cfg_fidx(cfg_fidx),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .in_l23_len(in_l23_len), .in_l234_len(in_l234_len), .in_filt(in_filt), .in_ts(in_ts),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last));

  always #10 clk = ~clk;

  int total = 0, bad = 0;
  int rdy_mode = 0;
  logic [7:0] lfsr = 8'h5a;
  logic [7:0] exp_q[$];
  bit last_q[$];
  string tag_q[$];
  bit m_en[NR];
  int m_prio[NR], m_off[NR], m_base[NR], m_fidx[NR];

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    total++; bad++;
    $display("FAIL watchdog: run hung, actual=running expected=done");
    finish_run();
  end

  initial forever begin
    @(negedge clk);
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    out_ready = (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? (lfsr[0] | lfsr[2]) : 1'b0;
  end

  bit frame_bad = 0;
  initial forever begin
    @(negedge clk); #5;
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL R2: unexpected byte actual=%02h expected=none", out_data);
      end else begin
        logic [7:0] e; bit el; string t;
        e = exp_q.pop_front(); el = last_q.pop_front(); t = tag_q[0];
        if (e !== out_data || el !== out_last) begin
          if (!frame_bad)
            $display("FAIL %s: actual=%02h/%0b expected=%02h/%0b", t, out_data, out_last, e, el);
          frame_bad = 1;
        end
        if (el) begin
          total++;
          if (frame_bad) bad++;
          frame_bad = 0;
          void'(tag_q.pop_front());
        end
      end
    end
  end

  task automatic cfg(input int idx, input bit en, input int prio, input int off,
                     input int base, input int fidx);
    @(negedge clk);
    cfg_we = 1; cfg_sel = 2'(idx); cfg_en = en; cfg_prio = PW'(prio);
    cfg_offset = 16'(off); cfg_base = 2'(base); cfg_fidx = 3'(fidx);
    m_en[idx] = en; m_prio[idx] = prio; m_off[idx] = off; m_base[idx] = base; m_fidx[idx] = fidx;
    @(negedge clk);
    cfg_we = 0;
  endtask

  function automatic int exp_cap(int len, int l23, int l234, logic [FW-1:0] filt);
    bit hit = 0; int bp = 0, cut = 0, lim;
    for (int i = 0; i < NR; i++) begin
      int c;
      c = m_off[i] + (m_base[i] == 1 ? l23 : m_base[i] == 2 ? l234 : 0);
      if (m_en[i] && filt[m_fidx[i]] && (!hit || m_prio[i] < bp)) begin
        hit = 1; bp = m_prio[i]; cut = c;
      end
    end
    lim = (hit && cut < len) ? cut : len;
    return (lim > DEPTH) ? DEPTH : lim;
  endfunction

  task automatic send(input int len, input int l23, input int l234,
                      input logic [FW-1:0] filt, input logic [63:0] ts, input string tag);
    int cap; logic [127:0] d;
    cap = exp_cap(len, l23, l234, filt);
    d = {32'h0, ts[31:0], ts[63:32], 16'(len), 16'(cap)};
    for (int k = 0; k < 16; k++) begin
      exp_q.push_back(d[k*8 +: 8]); last_q.push_back(cap == 0 && k == 15);
    end
    for (int k = 0; k < cap; k++) begin
      exp_q.push_back(8'(len + k * 7)); last_q.push_back(k == cap - 1);
    end
    tag_q.push_back(tag);
    @(negedge clk);
    for (int i = 0; i < len; i++) begin
      in_valid = 1; in_data = 8'(len + i * 7); in_last = (i == len - 1);
      in_l23_len = 16'(l23); in_l234_len = 16'(l234); in_filt = filt; in_ts = ts;
      #5;
      while (!in_ready) begin @(negedge clk); #5; end
      @(negedge clk);
    end
    in_valid = 0; in_last = 0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while ((exp_q.size() != 0 || out_valid) && n < 5000) begin @(negedge clk); n++; end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #5;
    total++;
    if (in_ready !== 1'b1 || out_valid !== 1'b0) begin
      bad++;
      $display("FAIL R1: actual ready=%0b valid=%0b expected ready=1 valid=0", in_ready, out_valid);
    end
    send(20, 14, 34, 8'h07, 64'h1122334455667788, "R1 R9 empty table");
    cfg(0, 1, 2, 12, 0, 0);
    rdy_mode = 1;
    send(30, 14, 34, 8'h01, 64'hA0A1A2A3B0B1B2B3, "R3 fixed cut");
    send(10, 14, 34, 8'h01, 64'h5, "R8 short frame");
    cfg(1, 1, 1, 4, 1, 1);
    send(50, 20, 40, 8'h03, 64'hCAFE, "R4 L23 base");
    cfg(2, 1, 0, 2, 2, 2);
    send(50, 20, 30, 8'h07, 64'hBEEF, "R5 R7 L234 base wins");
    send(50, 20, 30, 8'h01, 64'h77, "R6 only catch-all bit");
    cfg(2, 0, 0, 2, 2, 2);
    send(50, 20, 30, 8'h07, 64'h88, "R6 disabled rule");
    cfg(3, 1, 1, 6, 0, 1);
    send(40, 10, 30, 8'h03, 64'h99, "R7 tie lower index");
    send(24, 20, 30, 8'h03, 64'h9A, "R8 cut equals wire");
    rdy_mode = 0;
    send(100, 14, 34, 8'h00, 64'hFEEDFACE, "R10 R9 capacity");
    cfg(0, 1, 2, 0, 0, 0);
    send(30, 14, 34, 8'h01, 64'h123, "R12 zero cut");
    wait_idle();
    rdy_mode = 2;
    send(18, 14, 34, 8'h01, 64'h321, "R11 stall frame");
    repeat (3) @(negedge clk);
    #5;
    total++;
    if (out_valid !== 1'b1 || in_ready !== 1'b0 || out_data !== 8'h00) begin
      bad++;
      $display("FAIL R11: actual v=%0b r=%0b d=%02h expected v=1 r=0 d=00", out_valid, in_ready, out_data);
    end
    rdy_mode = 0;
    wait_idle();
    @(negedge clk);
    cfg(0, 1, 2, 5, 0, 0);
    rdy_mode = 1;
    send(12, 14, 34, 8'h01, 64'h456, "R11 after stall");
    wait_idle();
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule